// File: doc/BRIEF.md
# Interrupt Pending-Bit Controller

This block decides, for every per-vector interrupt request, whether a message goes out at once or is parked in a pending-bit array. It holds the function-wide enable and mask bits of the message control word. A request for a vector can be delivered only when the function is enabled, the function is not masked and the vector's own table mask is clear. Any other request sets that vector's pending bit. The pending array is read-only to software and is read as 64-bit words or as 32-bit halves.

Pending messages are replayed in two situations. When the function mask goes from set to clear, a scan walks every vector, one per cycle. It queues a send for each vector whose own mask is clear and whose pending bit is set. When the vector table reports that one vector's mask has been cleared, and the function is live, that one vector is queued if it is pending. Queued sends leave through a valid/ready channel that carries the vector index. The channel serves the lowest queued index first. Once `send_valid` is high, it and `send_vec` stay unchanged until `send_ready` is seen high at a clock edge. The pending bit of a vector is cleared in the same handshake.

Top module: `irq_pend_ctl`

## Requirements
- R1: After reset the function is masked and not enabled (control word bits 15:14 = 2'b01), the pending array reads all zero and `send_valid` is low.
- R2: A control write takes only bit 15 (enable) and bit 14 (mask). Bits 10:0 always read the vector count minus one, and bits 13:11 read zero.
- R3: A request for a deliverable vector raises `send_valid` with that index on the next cycle and leaves its pending bit clear.
- R4: A request that arrives while the function is disabled, the function is masked or the vector is masked sets the vector's pending bit and sends nothing.
- R5: Vector v lives in word v/64 at bit v mod 64. A 64-bit read at byte offset 8k returns word k. A 32-bit read at 8k+0 returns the low half of word k and a read at 8k+4 returns the high half, both in data bits 31:0. A read past the last word returns all ones (a 32-bit read returns 0x00000000FFFFFFFF). A misaligned offset returns zero.
- R6: A clear of the function mask starts a scan from vector 0, one vector per cycle, whatever the enable bit. The scan sends every pending vector whose own mask is clear, in ascending order, and clears its pending bit. Pending vectors that are still masked stay pending.
- R7: An unmask event for a pending vector sends it when the function is enabled and unmasked. While the function is masked the event changes nothing.
- R8: While `send_valid` is high and `send_ready` is low, `send_vec` holds. Among queued vectors the lowest index goes first.
- R9: During a scan, a request for a vector above the scan position is recorded as pending, and the scan then delivers it when it reaches that vector.
- R10: If a pending bit is set and cleared in the same cycle, the set wins.
- R11: Each location word is {offset[31:3], BAR[2:0]}, built from parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Message control word write strobe |
| ctl_wr_data | input | 16 | Message control write data |
| ctl_word | output | 16 | Current message control word |
| tbl_loc | output | 32 | Vector table location word |
| pba_loc | output | 32 | Pending array location word |
| irq_req | input | NUM_VEC | Per-vector interrupt request pulses |
| vec_mask | input | NUM_VEC | Per-vector mask bits from the vector table |
| unmask_evt | input | 1 | A vector's mask has just gone from 1 to 0 |
| unmask_idx | input | VEC_W | Vector named by the unmask event |
| send_valid | output | 1 | A message is to be sent |
| send_ready | input | 1 | Downstream accepts the message |
| send_vec | output | VEC_W | Vector index of the message |
| pba_rd_addr | input | ADDR_W | Byte offset into the pending array |
| pba_rd_wide | input | 1 | 1 = 64-bit read, 0 = 32-bit read |
| pba_rd_data | output | 64 | Read data, combinational from the address |

## Verification
The assertions assume that `irq_req`, `vec_mask`, `unmask_evt` and `send_ready` hold steady from one clock edge to the next. They also assume that an unmask event names a vector whose mask input is already clear. The stimulus changes inputs only on falling edges and always clears a mask bit in the same cycle as its event. It also leaves `send_ready` low while it checks the hold rule, so that the held index can be seen waiting.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned WORD_BITS = 64;
  localparam int unsigned CTL_W     = 16;
  localparam int unsigned EN_BIT    = 15;
  localparam int unsigned MASK_BIT  = 14;
  localparam int unsigned SIZE_W    = 11;

  function automatic logic [31:0] loc_word(input logic [31:0] off, input logic [2:0] bar);
    return {off[31:3], bar};
  endfunction
endpackage

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_VEC = 70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic             func_en,
  output logic             func_mask,
  output logic             mask_fall,
  output logic [CTL_W-1:0] ctl_word
);
  localparam logic [SIZE_W-1:0] SIZE_M1 = SIZE_W'(NUM_VEC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_en   <= 1'b0;
      func_mask <= 1'b1;
    end else if (wr_en) begin
      func_en   <= wr_data[EN_BIT];
      func_mask <= wr_data[MASK_BIT];
    end
  end

  assign mask_fall = wr_en && func_mask && !wr_data[MASK_BIT];
  assign ctl_word  = {func_en, func_mask, 3'b000, SIZE_M1};

  p_ctl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (func_en == $past(wr_data[EN_BIT])) && (func_mask == $past(wr_data[MASK_BIT])));
endmodule

// File: rtl/irq_replay_scan.sv
module irq_replay_scan #(
  parameter int unsigned NUM_VEC = 70,
  parameter int unsigned VEC_W   = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [VEC_W-1:0] ptr
);
  localparam logic [VEC_W-1:0] LAST = VEC_W'(NUM_VEC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == LAST) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end
  end

  p_scan_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && (ptr == '0));
  p_scan_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && ptr != LAST) |=> busy && (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/irq_send_pick.sv
module irq_send_pick #(
  parameter int unsigned NUM_VEC = 70,
  parameter int unsigned VEC_W   = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] due,
  input  logic               ready,
  output logic               valid,
  output logic [VEC_W-1:0]   vec
);
  logic [VEC_W-1:0] lowest;
  logic             hold_q;
  logic [VEC_W-1:0] hold_vec;

  always_comb begin
    lowest = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (due[i]) lowest = VEC_W'(i);
    end
  end

  assign valid = |due;
  assign vec   = hold_q ? hold_vec : lowest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      hold_vec <= '0;
    end else begin
      hold_q   <= valid && !ready;
      hold_vec <= vec;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid && (vec == $past(vec)));
endmodule

// File: rtl/irq_pba_rdport.sv
module irq_pba_rdport #(
  parameter int unsigned N_WORDS = 2,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic [N_WORDS*64-1:0] pba_flat,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wide,
  output logic [63:0]           data
);
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] word_idx;
  logic             in_range;
  logic [63:0]      word;

  assign word_idx = addr[ADDR_W-1:3];
  assign in_range = int'(word_idx) < N_WORDS;
  assign word     = in_range ? pba_flat[int'(word_idx)*64 +: 64] : '0;

  always_comb begin
    if (!in_range)           data = wide ? {64{1'b1}} : {32'h0, 32'hFFFF_FFFF};
    else if (wide)           data = (addr[2:0] == 3'b000) ? word : '0;
    else if (addr[1:0] != 0) data = '0;
    else                     data = {32'h0, addr[2] ? word[63:32] : word[31:0]};
  end
endmodule

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_VEC = 70,
  parameter int unsigned VEC_W   = $clog2(NUM_VEC),
  parameter int unsigned ADDR_W  = 12,
  parameter logic [2:0]  TBL_BAR = 3'd1,
  parameter logic [31:0] TBL_OFF = 32'h0000_1000,
  parameter logic [2:0]  PBA_BAR = 3'd4,
  parameter logic [31:0] PBA_OFF = 32'h0000_1800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr_en,
  input  logic [15:0]        ctl_wr_data,
  output logic [15:0]        ctl_word,
  output logic [31:0]        tbl_loc,
  output logic [31:0]        pba_loc,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic [NUM_VEC-1:0] vec_mask,
  input  logic               unmask_evt,
  input  logic [VEC_W-1:0]   unmask_idx,
  output logic               send_valid,
  input  logic               send_ready,
  output logic [VEC_W-1:0]   send_vec,
  input  logic [ADDR_W-1:0]  pba_rd_addr,
  input  logic               pba_rd_wide,
  output logic [63:0]        pba_rd_data
);
  localparam int unsigned N_WORDS  = NUM_VEC / WORD_BITS + 1;
  localparam int unsigned PBA_BITS = N_WORDS * WORD_BITS;

  logic func_en, func_mask, mask_fall, func_live;
  logic scan_busy;
  logic [VEC_W-1:0] scan_ptr;
  logic [NUM_VEC-1:0] pba_q, due_q, set_pba, set_due, clr;
  logic [PBA_BITS-1:0] pba_flat;
  logic fire;

  irq_ctl_reg #(.NUM_VEC(NUM_VEC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
    .func_en(func_en), .func_mask(func_mask), .mask_fall(mask_fall), .ctl_word(ctl_word)
  );

  irq_replay_scan #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(mask_fall), .busy(scan_busy), .ptr(scan_ptr)
  );

  irq_send_pick #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .due(due_q), .ready(send_ready),
    .valid(send_valid), .vec(send_vec)
  );

  irq_pba_rdport #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_rd (
    .pba_flat(pba_flat), .addr(pba_rd_addr), .wide(pba_rd_wide), .data(pba_rd_data)
  );

  assign func_live = func_en && !func_mask;
  assign fire      = send_valid && send_ready;
  assign tbl_loc   = loc_word(TBL_OFF, TBL_BAR);
  assign pba_loc   = loc_word(PBA_OFF, PBA_BAR);

  generate
    if (PBA_BITS > NUM_VEC) begin : g_pad
      assign pba_flat = {{(PBA_BITS - NUM_VEC){1'b0}}, pba_q};
    end else begin : g_nopad
      assign pba_flat = pba_q;
    end
  endgenerate

  // Per-vector routing: direct send, park as pending, or replay
  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      logic ahead, direct, evt_hit, scan_hit;
      ahead    = scan_busy && (v > int'(scan_ptr));
      direct   = func_live && !vec_mask[v] && !ahead;
      evt_hit  = unmask_evt && (int'(unmask_idx) == v) && func_live && pba_q[v];
      scan_hit = scan_busy && (int'(scan_ptr) == v) && !vec_mask[v] && pba_q[v];
      set_pba[v] = irq_req[v] && !direct;
      set_due[v] = (irq_req[v] && direct) || evt_hit || scan_hit;
      clr[v]     = fire && (int'(send_vec) == v);
    end
  end

  // Set wins over clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pba_q <= '0;
      due_q <= '0;
    end else begin
      pba_q <= (pba_q & ~clr) | set_pba;
      due_q <= (due_q & ~clr) | set_due;
    end
  end

  p_valid_owed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |-> due_q[send_vec]);

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_chk
    p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[g] && !func_live) |=> pba_q[g]);
  end
endmodule

// File: tb/sim_irq_pend_ctl.sv
module sim_irq_pend_ctl;
  localparam int NUM_VEC = 70;
  localparam int VEC_W   = $clog2(NUM_VEC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr_en = 1'b0;
  logic [15:0] ctl_wr_data = '0;
  logic [15:0] ctl_word;
  logic [31:0] tbl_loc, pba_loc;
  logic [NUM_VEC-1:0] irq_req = '0;
  logic [NUM_VEC-1:0] vec_mask = '0;
  logic unmask_evt = 1'b0;
  logic [VEC_W-1:0] unmask_idx = '0;
  logic send_valid;
  logic send_ready = 1'b0;
  logic [VEC_W-1:0] send_vec;
  logic [11:0] pba_rd_addr = '0;
  logic pba_rd_wide = 1'b1;
  logic [63:0] pba_rd_data;

  int checks = 0;
  int errors = 0;
  int sent_n = 0;
  int sent_v [0:63];
  logic [63:0] d;

  always #4 clk = ~clk;

  irq_pend_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_word(ctl_word), .tbl_loc(tbl_loc), .pba_loc(pba_loc),
    .irq_req(irq_req), .vec_mask(vec_mask), .unmask_evt(unmask_evt), .unmask_idx(unmask_idx),
    .send_valid(send_valid), .send_ready(send_ready), .send_vec(send_vec),
    .pba_rd_addr(pba_rd_addr), .pba_rd_wide(pba_rd_wide), .pba_rd_data(pba_rd_data)
  );

  // Record every completed handshake (inputs only move on falling edges)
  always @(posedge clk) begin
    if (rst_n && send_valid && send_ready) begin
      if (sent_n < 64) sent_v[sent_n] = int'(send_vec);
      sent_n = sent_n + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic w, output logic [63:0] q);
    pba_rd_addr = a;
    pba_rd_wide = w;
    #1;
    q = pba_rd_data;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk); ctl_wr_en = 1'b0;
  endtask

  task automatic pulse_req(input int v);
    @(negedge clk); irq_req = '0; irq_req[v] = 1'b1;
    @(negedge clk); irq_req = '0;
  endtask

  task automatic unmask(input int v);
    @(negedge clk); vec_mask[v] = 1'b0; unmask_evt = 1'b1; unmask_idx = VEC_W'(v);
    @(negedge clk); unmask_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 ctl word", ctl_word, 64'h4045);
    check("R1 send_valid", send_valid, 0);
    rd(12'h000, 1'b1, d); check("R1 word0", d, 0);
    rd(12'h008, 1'b1, d); check("R1 word1", d, 0);
    check("R11 table loc", tbl_loc, 64'h0000_1001);
    check("R11 pba loc", pba_loc, 64'h0000_1804);
  endtask

  task automatic t_ctl;
    wr_ctl(16'hFFFF); check("R2 all ones", ctl_word, 64'hC045);
    wr_ctl(16'h3FFF); check("R2 low bits ignored", ctl_word, 64'h0045);
    wr_ctl(16'h8000); check("R2 enable only", ctl_word, 64'h8045);
    idle(NUM_VEC + 4);
  endtask

  task automatic t_direct;
    int s0;
    send_ready = 1'b0;
    pulse_req(5);
    check("R3 valid", send_valid, 1);
    check("R3 vec", send_vec, 5);
    rd(12'h000, 1'b1, d); check("R3 no pending", d, 0);
    pulse_req(2);
    check("R8 held vec", send_vec, 5);
    s0 = sent_n;
    @(negedge clk); send_ready = 1'b1;
    idle(3); send_ready = 1'b0;
    check("R8 count", sent_n - s0, 2);
    check("R8 first", sent_v[s0], 5);
    check("R8 second lowest", sent_v[s0 + 1], 2);
    check("R8 drained", send_valid, 0);
  endtask

  task automatic t_pend;
    vec_mask[7] = 1'b1;
    pulse_req(7);
    check("R4 vector masked no send", send_valid, 0);
    wr_ctl(16'h0000);
    pulse_req(3);
    wr_ctl(16'hC000);
    pulse_req(66);
    check("R4 no send", send_valid, 0);
    rd(12'h000, 1'b1, d); check("R4/R5 word0", d, 64'h88);
    rd(12'h008, 1'b1, d); check("R5 word1", d, 64'h4);
    rd(12'h000, 1'b0, d); check("R5 low half", d, 64'h88);
    rd(12'h004, 1'b0, d); check("R5 high half", d, 0);
    rd(12'h008, 1'b0, d); check("R5 word1 low", d, 64'h4);
    rd(12'h00C, 1'b0, d); check("R5 word1 high", d, 0);
    rd(12'h010, 1'b1, d); check("R5 past end wide", d, {64{1'b1}});
    rd(12'h014, 1'b0, d); check("R5 past end narrow", d, 64'hFFFF_FFFF);
    rd(12'h004, 1'b1, d); check("R5 misaligned wide", d, 0);
  endtask

  task automatic t_scan;
    int s0;
    s0 = sent_n;
    send_ready = 1'b1;
    wr_ctl(16'h8000);
    idle(NUM_VEC + 6);
    check("R6 count", sent_n - s0, 2);
    check("R6 first", sent_v[s0], 3);
    check("R6 second", sent_v[s0 + 1], 66);
    rd(12'h000, 1'b1, d); check("R6 masked stays", d, 64'h80);
    rd(12'h008, 1'b1, d); check("R6 word1 cleared", d, 0);
  endtask

  task automatic t_unmask;
    int s0;
    send_ready = 1'b1;
    s0 = sent_n;
    unmask(7);
    idle(3);
    check("R7 sent count", sent_n - s0, 1);
    check("R7 sent vec", sent_v[s0], 7);
    rd(12'h000, 1'b1, d); check("R7 cleared", d, 0);
    wr_ctl(16'hC000);
    vec_mask[9] = 1'b1;
    pulse_req(9);
    s0 = sent_n;
    unmask(9);
    idle(3);
    check("R7 func masked no send", sent_n - s0, 0);
    rd(12'h000, 1'b1, d); check("R7 still pending", d, 64'h200);
    wr_ctl(16'h8000);
    idle(NUM_VEC + 6);
    check("R6 replay after unmask", sent_v[s0], 9);
    rd(12'h000, 1'b1, d); check("R6 cleared 9", d, 0);
  endtask

  task automatic t_race;
    int s0;
    send_ready = 1'b1;
    wr_ctl(16'hC000);
    pulse_req(1);
    s0 = sent_n;
    @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = 16'h8000;
    @(negedge clk); ctl_wr_en = 1'b0;
    @(negedge clk); irq_req[60] = 1'b1;
    @(negedge clk); irq_req = '0;
    rd(12'h000, 1'b1, d); check("R9 recorded pending", d[60], 1);
    check("R9 nothing sent yet", sent_n - s0, 0);
    idle(NUM_VEC + 6);
    check("R9 count", sent_n - s0, 2);
    check("R9 first", sent_v[s0], 1);
    check("R9 scan delivers", sent_v[s0 + 1], 60);
    rd(12'h000, 1'b1, d); check("R9 cleared", d, 0);
    send_ready = 1'b0;
  endtask

  task automatic t_setwins;
    int s0;
    send_ready = 1'b0;
    wr_ctl(16'hC000);
    pulse_req(4);
    wr_ctl(16'h8000);
    idle(10);
    check("R10 queued valid", send_valid, 1);
    check("R10 queued vec", send_vec, 4);
    s0 = sent_n;
    @(negedge clk); vec_mask[4] = 1'b1; irq_req[4] = 1'b1; send_ready = 1'b1;
    @(negedge clk); irq_req = '0; send_ready = 1'b0;
    check("R10 sent", sent_n - s0, 1);
    rd(12'h000, 1'b1, d); check("R10 set wins", d, 64'h10);
    send_ready = 1'b1;
    unmask(4);
    idle(NUM_VEC + 4);
    check("R10 resent", sent_v[s0 + 1], 4);
    rd(12'h000, 1'b1, d); check("R10 cleared", d, 0);
    send_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_direct();
    t_pend();
    t_scan();
    t_unmask();
    t_race();
    t_setwins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule